// File: doc/BRIEF.md
# I2C Master Bus Condition Sequencer

This block generates the bus conditions an I2C master needs: START, STOP and a repeated START. It pulls the open-drain SCL and SDA wires low or lets them go, and it watches the sampled wire levels. Separately, it keeps a bus-busy flag that follows every START and STOP seen on the wires, whether this master or another one made it. Byte shifting and addressing sit in a neighbouring block, which issues one-cycle command strobes here while `ready_o` is high and waits for `done_o`.

A STOP allows for clock stretching. SDA is pulled low, SCL is let go, and the block waits until the SCL wire really reads high before the setup time runs and SDA rises. A repeated START is not a single combined edge. The block first lets go of both wires, which is not a STOP, so the bus stays busy. It then waits until the setup time, counted from the command, has elapsed and the SCL wire is seen high. Only then does it run a normal START. The setup time depends on the mode (standard or fast) and is latched when the command is taken. It is a cycle count derived from the clock frequency.

Top module: `i2c_cond_seq`

## Requirements
- R1: During and after reset, `scl_drive_o`=0, `sda_drive_o`=0, `busy_o`=0, `done_o`=0 and `ready_o`=1.
- R2: A start command pulls SDA low while SCL is released. After the setup count it also pulls SCL low and pulses `done_o` in that same cycle, which is the setup count in cycles after the accepting edge. Afterwards both wires stay pulled low (the bus is owned).
- R3: A stop command pulls SDA low, then releases SCL. SDA is released only after the SCL wire has been sampled high and the setup count has elapsed. If another device holds SCL low, SDA stays low and no `done_o` appears until SCL is freed. At the end both wires are released.
- R4: A restart command releases both wires in the cycle after it is accepted. The new SDA fall happens only once the setup count, counted from the accepting edge, has elapsed and the SCL wire reads high. `done_o` comes a further setup count later, with both wires pulled low.
- R5: The setup count is ceil(4.7 us × clock) in standard mode (`fast_i`=0) and ceil(0.6 us × clock) in fast mode (`fast_i`=1). That is 1175 and 150 cycles at 250 MHz. `fast_i` is sampled only when a command is accepted.
- R6: `busy_o` sets after SDA falls while SCL is high, and clears after SDA rises while SCL is high. SCL must read high in two successive synchronized samples. This applies to conditions made by any master.
- R7: The release phase of a restart does not clear `busy_o`.
- R8: `done_o` lasts exactly one cycle and never coincides with `ready_o`. `ready_o` is low from the accepting edge until the cycle after `done_o`.
- R9: A command strobe given while `ready_o` is low is ignored, including one given in the `done_o` cycle.
- R10: When several strobes arrive together, stop wins over restart, and restart wins over start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START command strobe |
| stop_i | input | 1 | STOP command strobe |
| restart_i | input | 1 | Repeated-START command strobe |
| fast_i | input | 1 | 1 selects fast-mode setup count |
| scl_i | input | 1 | Sampled SCL wire level |
| sda_i | input | 1 | Sampled SDA wire level |
| scl_drive_o | output | 1 | 1 pulls SCL low |
| sda_drive_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Bus busy between detected START and STOP |
| ready_o | output | 1 | Commands are accepted |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The sequencer's `done_o` for a STOP and the line monitor's detection of that same STOP edge fall within a few cycles of each other. A fresh command strobe can also land exactly in the `done_o` cycle. The bench places a start strobe in the STOP's `done_o` cycle. It then judges at the ports that the strobe left both wires released and `ready_o` high, and that `busy_o` still fell a few cycles later. Simultaneous strobes are also given in one cycle, and the end state of the wires tells which command ran.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_S_SDA,   // SDA low, SCL free, hold time
    CS_S_SCL,   // SCL low, start finished
    CS_P_SDA,   // SDA low before SCL release
    CS_P_REL,   // SCL released, wait wire high
    CS_P_SU,    // stop setup with SCL high
    CS_P_END,   // SDA released
    CS_R_WAIT   // restart: both released, wait setup and free SCL
  } cond_state_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic busy_o
);

  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic scl_p_q, sda_p_q, busy_q;
  logic start_det, stop_det;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sync_q <= '1;
          sda_sync_q <= '1;
        end else begin
          scl_sync_q <= scl_i;
          sda_sync_q <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sync_q <= '1;
          sda_sync_q <= '1;
        end else begin
          scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
          sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_o = scl_sync_q[SYNC_STAGES-1];
  assign sda_o = sda_sync_q[SYNC_STAGES-1];

  // SCL must be steady high so a joint release is not read as a condition
  assign start_det = scl_o && scl_p_q && sda_p_q && !sda_o;
  assign stop_det  = scl_o && scl_p_q && !sda_p_q && sda_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
      busy_q  <= 1'b0;
    end else begin
      scl_p_q <= scl_o;
      sda_p_q <= sda_o;
      if (start_det)     busy_q <= 1'b1;
      else if (stop_det) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int unsigned STD_CYC  = 1175,
  parameter int unsigned FAST_CYC = 150
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic fast_i,
  output logic reached_o
);

  localparam int unsigned MAX_CYC = (STD_CYC > FAST_CYC) ? STD_CYC : FAST_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] STD_LIM  = CNT_W'(STD_CYC - 1);
  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim = fast_i ? FAST_LIM : STD_LIM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q < lim)     cnt_q <= cnt_q + 1'b1;
  end

  assign reached_o = (cnt_q >= lim);

endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
  import i2c_cond_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic restart_i,
  input  logic fast_i,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic reached_i,
  output logic fast_o,
  output logic clr_o,
  output logic scl_drive_o,
  output logic sda_drive_o,
  output logic ready_o,
  output logic done_o
);

  cond_state_e state_q, state_d;
  logic own_q, own_d;
  logic fast_q, fast_d;

  always_comb begin
    state_d = state_q;
    own_d   = own_q;
    fast_d  = fast_q;
    unique case (state_q)
      CS_IDLE: begin
        if (stop_i) begin
          state_d = CS_P_SDA;
          fast_d  = fast_i;
        end else if (restart_i) begin
          state_d = CS_R_WAIT;
          own_d   = 1'b0;
          fast_d  = fast_i;
        end else if (start_i) begin
          state_d = CS_S_SDA;
          fast_d  = fast_i;
        end
      end
      CS_S_SDA:  if (reached_i) state_d = CS_S_SCL;
      CS_S_SCL: begin
        own_d   = 1'b1;
        state_d = CS_IDLE;
      end
      CS_P_SDA: begin
        if (reached_i) begin
          state_d = CS_P_REL;
          own_d   = 1'b0;
        end
      end
      CS_P_REL:  if (scl_s_i) state_d = CS_P_SU;
      CS_P_SU:   if (reached_i) state_d = CS_P_END;
      CS_P_END:  state_d = CS_IDLE;
      CS_R_WAIT: if (reached_i && scl_s_i && sda_s_i) state_d = CS_S_SDA;
      default:   state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CS_IDLE;
      own_q   <= 1'b0;
      fast_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      own_q   <= own_d;
      fast_q  <= fast_d;
    end
  end

  always_comb begin
    scl_drive_o = 1'b0;
    sda_drive_o = 1'b0;
    ready_o     = 1'b0;
    done_o      = 1'b0;
    unique case (state_q)
      CS_IDLE: begin
        scl_drive_o = own_q;
        sda_drive_o = own_q;
        ready_o     = 1'b1;
      end
      CS_S_SDA: sda_drive_o = 1'b1;
      CS_S_SCL: begin
        sda_drive_o = 1'b1;
        scl_drive_o = 1'b1;
        done_o      = 1'b1;
      end
      CS_P_SDA: begin
        sda_drive_o = 1'b1;
        scl_drive_o = own_q;
      end
      CS_P_REL, CS_P_SU: sda_drive_o = 1'b1;
      CS_P_END: done_o = 1'b1;
      default: ;
    endcase
  end

  assign clr_o  = (state_d != state_q);
  assign fast_o = fast_q;

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq #(
  parameter int unsigned CLK_MHZ     = 250,
  parameter int unsigned STD_SU_NS   = 4700,
  parameter int unsigned FAST_SU_NS  = 600,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic restart_i,
  input  logic fast_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_drive_o,
  output logic sda_drive_o,
  output logic busy_o,
  output logic ready_o,
  output logic done_o
);

  localparam int unsigned STD_CYC  = i2c_cond_pkg::ns_to_cyc(STD_SU_NS, CLK_MHZ);
  localparam int unsigned FAST_CYC = i2c_cond_pkg::ns_to_cyc(FAST_SU_NS, CLK_MHZ);

  logic scl_s, sda_s, reached, tmr_clr, fast_q;

  i2c_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .scl_o  (scl_s),
    .sda_o  (sda_s),
    .busy_o (busy_o)
  );

  i2c_phase_timer #(.STD_CYC(STD_CYC), .FAST_CYC(FAST_CYC)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tmr_clr),
    .fast_i    (fast_q),
    .reached_o (reached)
  );

  i2c_cond_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .restart_i   (restart_i),
    .fast_i      (fast_i),
    .scl_s_i     (scl_s),
    .sda_s_i     (sda_s),
    .reached_i   (reached),
    .fast_o      (fast_q),
    .clr_o       (tmr_clr),
    .scl_drive_o (scl_drive_o),
    .sda_drive_o (sda_drive_o),
    .ready_o     (ready_o),
    .done_o      (done_o)
  );

endmodule

// File: rtl/i2c_cond_seq_chk.sv
module i2c_cond_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_i,
  input logic scl_drive_o,
  input logic sda_drive_o,
  input logic busy_o,
  input logic ready_o,
  input logic done_o
);

  p_stop_edge_scl_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sda_drive_o) && !scl_drive_o && !$past(scl_drive_o)) |-> scl_i);

  p_sda_before_scl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_drive_o) |-> sda_drive_o);

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_not_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ready_o);

  p_busy_clear_sda_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (sda_i && scl_i));

  p_ready_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o);

endmodule

bind i2c_cond_seq i2c_cond_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .sda_i       (sda_i),
  .scl_drive_o (scl_drive_o),
  .sda_drive_o (sda_drive_o),
  .busy_o      (busy_o),
  .ready_o     (ready_o),
  .done_o      (done_o)
);

// File: tb/tb_i2c_cond_seq.sv
module tb_i2c_cond_seq;

  localparam int STD_T  = 1175;  // 4.7 us at 250 MHz
  localparam int FAST_T = 150;   // 0.6 us at 250 MHz

  typedef struct packed {
    logic [1:0] op;      // 1 start, 2 stop, 3 restart
    logic       fast;
    logic       exp_own;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{op: 2'd1, fast: 1'b0, exp_own: 1'b1},
    '{op: 2'd2, fast: 1'b0, exp_own: 1'b0},
    '{op: 2'd1, fast: 1'b1, exp_own: 1'b1},
    '{op: 2'd3, fast: 1'b1, exp_own: 1'b1},
    '{op: 2'd3, fast: 1'b0, exp_own: 1'b1},
    '{op: 2'd2, fast: 1'b1, exp_own: 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, restart = 1'b0, fast = 1'b0;
  logic slave_hold = 1'b0, ext_sda_low = 1'b0;
  logic scl_line, sda_line;
  logic scl_drv, sda_drv, busy, ready, done;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign scl_line = ~(scl_drv | slave_hold);
  assign sda_line = ~(sda_drv | ext_sda_low);

  i2c_cond_seq dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .stop_i      (stop),
    .restart_i   (restart),
    .fast_i      (fast),
    .scl_i       (scl_line),
    .sda_i       (sda_line),
    .scl_drive_o (scl_drv),
    .sda_drive_o (sda_drv),
    .busy_o      (busy),
    .ready_o     (ready),
    .done_o      (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic strobe(input logic [1:0] op, input logic f);
    @(negedge clk);
    fast = f;
    start = (op == 2'd1);
    stop = (op == 2'd2);
    restart = (op == 2'd3);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; stop = 1'b0; restart = 1'b0;
  endtask

  // called right after strobe(); counts cycles from the accepting edge
  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 50000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, t, lo;
    idle(3);
    // R1 reset state
    chk("R1 scl_drive", scl_drv, 0);
    chk("R1 sda_drive", sda_drv, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ready", ready, 1);
    chk("R1 done", done, 0);
    rst_n = 1'b1;
    idle(4);

    // table walk: R2 R3 R4 R5 R6 R8
    foreach (VEC[i]) begin
      t  = VEC[i].fast ? FAST_T : STD_T;
      lo = (VEC[i].op == 2'd1) ? t : 2 * t;
      chk("R8 ready before cmd", ready, 1);
      strobe(VEC[i].op, VEC[i].fast);
      chk("R8 ready low in sequence", ready, 0);
      wait_done(n);
      if (VEC[i].op == 2'd1) chk("R2 R5 start done cycle", n, t);
      else chk_rng("R3 R4 R5 done cycle", n, lo, lo + 12);
      chk("R2 R3 R4 scl end state", scl_drv, VEC[i].exp_own);
      chk("R2 R3 R4 sda end state", sda_drv, VEC[i].exp_own);
      @(negedge clk);
      chk("R8 done one cycle", done, 0);
      chk("R8 ready after done", ready, 1);
      idle(8);
      chk("R6 busy after sequence", busy, VEC[i].exp_own);
    end

    // R6 conditions from another master
    ext_sda_low = 1'b1;
    idle(6);
    chk("R6 foreign start sets busy", busy, 1);
    ext_sda_low = 1'b0;
    idle(6);
    chk("R6 foreign stop clears busy", busy, 0);

    // R3 stop against a held SCL
    strobe(2'd1, 1'b1);
    wait_done(n);
    idle(2);
    slave_hold = 1'b1;
    strobe(2'd2, 1'b1);
    n = 0;
    repeat (3 * FAST_T) begin
      if (done) n++;
      @(negedge clk);
    end
    chk("R3 no done while SCL held", n, 0);
    chk("R3 SDA kept low while SCL held", sda_drv, 1);
    chk("R3 SCL released by master", scl_drv, 0);
    slave_hold = 1'b0;
    wait_done(n);
    chk_rng("R3 stop ends after SCL freed", n, FAST_T, FAST_T + 12);
    chk("R3 sda released at end", sda_drv, 0);
    idle(8);
    chk("R3 busy cleared", busy, 0);

    // R4 R7 restart parked by a held SCL
    strobe(2'd1, 1'b0);
    wait_done(n);
    idle(2);
    slave_hold = 1'b1;
    strobe(2'd3, 1'b0);
    chk("R4 SCL released at once", scl_drv, 0);
    chk("R4 SDA released at once", sda_drv, 0);
    idle(2 * STD_T);
    chk("R4 no SDA fall while SCL held", sda_drv, 0);
    chk("R7 busy kept through release", busy, 1);
    slave_hold = 1'b0;
    wait_done(n);
    chk_rng("R4 start after SCL free", n, STD_T, STD_T + 12);
    chk("R4 owned after restart", scl_drv, 1);

    // R9 start strobe in the done cycle of a stop; busy clears meanwhile
    strobe(2'd2, 1'b1);
    wait_done(n);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R9 ready after ignored start", ready, 1);
    idle(20);
    chk("R9 sda untouched", sda_drv, 0);
    chk("R9 scl untouched", scl_drv, 0);
    chk("R9 still ready", ready, 1);
    chk("R6 busy cleared alongside", busy, 0);

    // R10 simultaneous strobes: stop must win
    strobe(2'd1, 1'b1);
    wait_done(n);
    idle(2);
    @(negedge clk);
    fast = 1'b1; start = 1'b1; stop = 1'b1; restart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; stop = 1'b0; restart = 1'b0;
    wait_done(n);
    chk_rng("R10 stop timing", n, 2 * FAST_T, 2 * FAST_T + 12);
    chk("R10 scl released", scl_drv, 0);
    chk("R10 sda released", sda_drv, 0);
    idle(8);
    chk("R10 busy cleared", busy, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule